// File: doc/BRIEF.md
# Multiplexed LCD Common/Segment Sequencer

This block produces the time-multiplexed drive pattern for a passive LCD panel. For every common pin and every segment pin it emits a 2-bit drive-level code each cycle. An external resistor ladder or switch network turns each code into a voltage: 0 is ground, 1 is the lower intermediate level, 2 is the upper intermediate level and 3 is the full panel supply. The display image is a parallel register with four bits per segment, one for each common.

Static configuration inputs control the block:
- the number of commons (three or four);
- the bias (one-half or one-third);
- a 2-bit frame-rate selector;
- a sleep request and a blank (all segments off) request;
- a per-pin enable that turns each of the first few segment pins into a static output port.

At three-common operation the fourth common pin becomes one more segment pin. The polarity of the waveform flips after every frame, so each pin averages to zero DC.

An internal prescaler sets how long each phase lasts. A phase counter walks through the active commons. The polarity bit toggles each time the counter wraps. Every output is a pure function of this small state and the configuration, so configuration changes take effect in the same cycle.

Top module: `lcd_mux_seq`

## Requirements
- R1: While rst_n is low the phase is 0, the polarity is 0 and the prescaler is cleared. With one-third bias this gives com_lvl = 8'h57 (common 0 at code 3, the others at code 1).
- R2: When not sleeping, the phase advances once every BASE_DIV << cfg_rate cycles. The prescaler compares with greater-or-equal, so a smaller ratio takes effect at once.
- R3: With cfg_quarter=1 the phase runs 0,1,2,3; with cfg_quarter=0 it runs 0,1,2. Common i is selected only during phase i, where it is at code 3 (polarity 0) or code 0 (polarity 1).
- R4: An unselected common is at code 1 at one-third bias with polarity 0, and at code 2 with polarity 1. At one-half bias it is at code 1 (the midpoint) in both polarities.
- R5: Segment j is on in a phase when disp_data[j*4+phase] is 1. An on segment takes the extreme opposite to the selected common: code 0 for polarity 0 and code 3 for polarity 1. An off segment is at code 2 or 1 at one-third bias, and at code 3 or 0 at one-half bias (again for polarity 0 or 1).
- R6: The polarity toggles on the step that wraps the phase back to 0, and at no other step.
- R7: With cfg_quarter=0, com_lvl[7:6] drives a segment waveform whose data bit is disp_data[N_SEG*4+phase].
- R8: With cfg_blank=1, every segment output, including the fourth common pin in three-common operation, takes the off waveform, and the commons keep scanning.
- R9: For j < N_PORT with cfg_port_en[j]=1, seg_lvl[2j+:2] is 3 when port_val[j] is 1 and 0 otherwise. This holds whatever the phase, the polarity, cfg_blank or the display data.
- R10: With cfg_sleep=1 every output is code 0 and the prescaler, phase and polarity hold. Clearing cfg_sleep resumes from the held state.
- R11: If cfg_quarter drops while the phase is 3, the next phase step wraps to 0 and toggles the polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| cfg_quarter | input | 1 | 1 = four commons, 0 = three commons |
| cfg_third_bias | input | 1 | 1 = one-third bias, 0 = one-half bias |
| cfg_rate | input | 2 | frame-rate divide selector |
| cfg_sleep | input | 1 | sleep: ground all outputs, freeze the counters |
| cfg_blank | input | 1 | force every segment off |
| cfg_port_en | input | N_PORT | per-pin port mode for the first segment pins |
| port_val | input | N_PORT | port output values |
| disp_data | input | (N_SEG+1)*4 | display image, four bits per segment |
| com_lvl | output | 8 | common drive codes, 2 bits per common |
| seg_lvl | output | N_SEG*2 | segment drive codes, 2 bits per segment |

## Verification
The main collision is a phase step that wraps the frame in the same cycle that the configuration changes under it. The bench provokes it by dropping cfg_quarter exactly while the phase is 3, and by raising or lowering sleep on a step boundary. In these cycles the polarity toggle, the wrap and the output muxing all resolve together. The behavioural reference model steps its own counters and is compared on every cycle, so a one-cycle slip in the wrap, the toggle or the freeze shows up as a mismatch.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  typedef logic [1:0] lvl_t;

  localparam lvl_t LVL_GND = 2'd0;
  localparam lvl_t LVL_LO  = 2'd1;
  localparam lvl_t LVL_HI  = 2'd2;
  localparam lvl_t LVL_TOP = 2'd3;

  localparam int N_COM = 4;

  // Common level from selection, polarity and bias.
  function automatic lvl_t com_code(input logic sel, input logic pol,
                                    input logic third);
    lvl_t r;
    if (sel)        r = pol ? LVL_GND : LVL_TOP;
    else if (third) r = pol ? LVL_HI  : LVL_LO;
    else            r = LVL_LO;
    return r;
  endfunction

  // Segment level from on/off state, polarity and bias.
  function automatic lvl_t seg_code(input logic on, input logic pol,
                                    input logic third);
    lvl_t r;
    if (on)         r = pol ? LVL_TOP : LVL_GND;
    else if (third) r = pol ? LVL_LO  : LVL_HI;
    else            r = pol ? LVL_GND : LVL_TOP;
    return r;
  endfunction

  // Static port level.
  function automatic lvl_t port_code(input logic v);
    return v ? LVL_TOP : LVL_GND;
  endfunction

  // Last prescaler count of one phase.
  function automatic int step_last(input int base, input logic [1:0] rate);
    return (base << rate) - 1;
  endfunction

  // Last phase index of one frame.
  function automatic logic [1:0] phase_last(input logic quarter);
    return quarter ? 2'd3 : 2'd2;
  endfunction

endpackage

// File: rtl/lcd_seq_timer.sv
module lcd_seq_timer
  import lcd_seq_pkg::*;
#(
  parameter int BASE_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       quarter,
  input  logic [1:0] rate,
  output logic [1:0] phase,
  output logic       pol,
  output logic       tick,
  output logic       frame_end
);

  localparam int CNT_W = $clog2(BASE_DIV * 8) + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit     = CNT_W'(step_last(BASE_DIV, rate));
  assign tick      = run && (cnt >= limit);
  assign frame_end = (phase >= phase_last(quarter));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 2'd0;
      pol   <= 1'b0;
    end else if (run) begin
      if (tick) begin
        cnt <= '0;
        if (frame_end) begin
          phase <= 2'd0;
          pol   <= ~pol;
        end else begin
          phase <= phase + 2'd1;
        end
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/lcd_com_drv.sv
module lcd_com_drv
  import lcd_seq_pkg::*;
(
  input  logic       sleep,
  input  logic       blank,
  input  logic       quarter,
  input  logic       third,
  input  logic [1:0] phase,
  input  logic       pol,
  input  logic [3:0] xseg_bits,
  output logic [2*N_COM-1:0] com_lvl
);

  logic xseg_on;
  assign xseg_on = !blank && xseg_bits[phase];

  for (genvar i = 0; i < N_COM; i++) begin : g_com
    lvl_t lvl;
    if (i == N_COM - 1) begin : g_shared
      always_comb begin
        if (sleep)        lvl = LVL_GND;
        else if (!quarter) lvl = seg_code(xseg_on, pol, third);
        else              lvl = com_code(phase == 2'(i), pol, third);
      end
    end else begin : g_plain
      always_comb begin
        if (sleep) lvl = LVL_GND;
        else       lvl = com_code(phase == 2'(i), pol, third);
      end
    end
    assign com_lvl[2*i +: 2] = lvl;
  end

endmodule

// File: rtl/lcd_seg_drv.sv
module lcd_seg_drv
  import lcd_seq_pkg::*;
#(
  parameter int N_SEG  = 38,
  parameter int N_PORT = 4
) (
  input  logic                sleep,
  input  logic                blank,
  input  logic                third,
  input  logic [1:0]          phase,
  input  logic                pol,
  input  logic [N_PORT-1:0]   port_en,
  input  logic [N_PORT-1:0]   port_val,
  input  logic [N_SEG*4-1:0]  seg_bits,
  output logic [N_SEG*2-1:0]  seg_lvl
);

  for (genvar j = 0; j < N_SEG; j++) begin : g_seg
    logic [3:0] row;
    logic       on;
    lvl_t       lvl;
    assign row = seg_bits[j*4 +: 4];
    assign on  = !blank && row[phase];
    if (j < N_PORT) begin : g_port
      always_comb begin
        if (sleep)            lvl = LVL_GND;
        else if (port_en[j])  lvl = port_code(port_val[j]);
        else                  lvl = seg_code(on, pol, third);
      end
    end else begin : g_disp
      always_comb begin
        if (sleep) lvl = LVL_GND;
        else       lvl = seg_code(on, pol, third);
      end
    end
    assign seg_lvl[2*j +: 2] = lvl;
  end

endmodule

// File: rtl/lcd_mux_seq.sv
module lcd_mux_seq
  import lcd_seq_pkg::*;
#(
  parameter int N_SEG    = 38,
  parameter int N_PORT   = 4,
  parameter int BASE_DIV = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_quarter,
  input  logic                     cfg_third_bias,
  input  logic [1:0]               cfg_rate,
  input  logic                     cfg_sleep,
  input  logic                     cfg_blank,
  input  logic [N_PORT-1:0]        cfg_port_en,
  input  logic [N_PORT-1:0]        port_val,
  input  logic [(N_SEG+1)*4-1:0]   disp_data,
  output logic [7:0]               com_lvl,
  output logic [N_SEG*2-1:0]       seg_lvl
);

  localparam int SEG_BITS = N_SEG * 4;

  logic [1:0] phase;
  logic       pol;
  logic       tick;
  logic       frame_end;

  lcd_seq_timer #(.BASE_DIV(BASE_DIV)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (!cfg_sleep),
    .quarter   (cfg_quarter),
    .rate      (cfg_rate),
    .phase     (phase),
    .pol       (pol),
    .tick      (tick),
    .frame_end (frame_end)
  );

  lcd_com_drv u_com (
    .sleep     (cfg_sleep),
    .blank     (cfg_blank),
    .quarter   (cfg_quarter),
    .third     (cfg_third_bias),
    .phase     (phase),
    .pol       (pol),
    .xseg_bits (disp_data[SEG_BITS +: 4]),
    .com_lvl   (com_lvl)
  );

  lcd_seg_drv #(.N_SEG(N_SEG), .N_PORT(N_PORT)) u_seg (
    .sleep    (cfg_sleep),
    .blank    (cfg_blank),
    .third    (cfg_third_bias),
    .phase    (phase),
    .pol      (pol),
    .port_en  (cfg_port_en),
    .port_val (port_val),
    .seg_bits (disp_data[SEG_BITS-1:0]),
    .seg_lvl  (seg_lvl)
  );

endmodule

// File: rtl/lcd_seq_chk.sv
module lcd_seq_chk #(
  parameter int N_SEG  = 38,
  parameter int N_PORT = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_quarter,
  input logic                cfg_third_bias,
  input logic                cfg_sleep,
  input logic                cfg_blank,
  input logic [N_PORT-1:0]   cfg_port_en,
  input logic [N_PORT-1:0]   port_val,
  input logic [7:0]          com_lvl,
  input logic [N_SEG*2-1:0]  seg_lvl,
  input logic [1:0]          phase,
  input logic                pol,
  input logic                tick,
  input logic                frame_end
);

  logic [3:0] com_extreme;
  for (genvar i = 0; i < 4; i++) begin : g_ext
    assign com_extreme[i] = (com_lvl[2*i +: 2] == 2'd0) ||
                            (com_lvl[2*i +: 2] == 2'd3);
  end

  logic [1:0] free_seg;
  assign free_seg = seg_lvl[2*N_PORT +: 2];

  // R10
  sleep_ground_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sleep |-> (com_lvl == '0) && (seg_lvl == '0));

  // R10
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sleep |=> (phase == $past(phase)) && (pol == $past(pol)));

  // R6
  pol_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && frame_end) |=> (pol != $past(pol)) && (phase == 2'd0));

  // R6
  pol_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && frame_end) |=> (pol == $past(pol)));

  // R3
  third_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cfg_quarter) |=> (phase != 2'd3));

  // R3
  one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_sleep && cfg_quarter && cfg_third_bias) |-> $countones(com_extreme) == 1);

  // R9
  port_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_port_en[0] && !cfg_sleep) |-> seg_lvl[1:0] == (port_val[0] ? 2'd3 : 2'd0));

  // R8
  blank_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_blank && !cfg_sleep && cfg_third_bias) |-> (free_seg == 2'd1 || free_seg == 2'd2));

endmodule

bind lcd_mux_seq lcd_seq_chk #(.N_SEG(N_SEG), .N_PORT(N_PORT)) u_lcd_seq_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_quarter    (cfg_quarter),
  .cfg_third_bias (cfg_third_bias),
  .cfg_sleep      (cfg_sleep),
  .cfg_blank      (cfg_blank),
  .cfg_port_en    (cfg_port_en),
  .port_val       (port_val),
  .com_lvl        (com_lvl),
  .seg_lvl        (seg_lvl),
  .phase          (phase),
  .pol            (pol),
  .tick           (tick),
  .frame_end      (frame_end)
);

// File: tb/test_lcd_mux_seq.sv
module test_lcd_mux_seq;

  localparam int N_SEG    = 38;
  localparam int N_PORT   = 4;
  localparam int BASE_DIV = 4;
  localparam int DW       = (N_SEG + 1) * 4;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 cfg_quarter = 1'b1;
  logic                 cfg_third_bias = 1'b1;
  logic [1:0]           cfg_rate = 2'd0;
  logic                 cfg_sleep = 1'b0;
  logic                 cfg_blank = 1'b0;
  logic [N_PORT-1:0]    cfg_port_en = '0;
  logic [N_PORT-1:0]    port_val = '0;
  logic [DW-1:0]        disp_data = '0;
  logic [7:0]           com_lvl;
  logic [N_SEG*2-1:0]   seg_lvl;

  always #2 clk = ~clk;

  lcd_mux_seq #(.N_SEG(N_SEG), .N_PORT(N_PORT), .BASE_DIV(BASE_DIV)) i_lcd_mux_seq (
    .clk(clk), .rst_n(rst_n), .cfg_quarter(cfg_quarter),
    .cfg_third_bias(cfg_third_bias), .cfg_rate(cfg_rate),
    .cfg_sleep(cfg_sleep), .cfg_blank(cfg_blank),
    .cfg_port_en(cfg_port_en), .port_val(port_val),
    .disp_data(disp_data), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );

  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_cnt = 0, m_phase = 0, m_pol = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_phase = 0; m_pol = 0;
    end else if (!cfg_sleep) begin
      if (m_cnt + 1 >= BASE_DIV * (1 << cfg_rate)) begin
        m_cnt = 0;
        if (m_phase + 1 >= (cfg_quarter ? 4 : 3)) begin
          m_phase = 0;
          m_pol   = 1 - m_pol;
        end else begin
          m_phase = m_phase + 1;
        end
      end else begin
        m_cnt = m_cnt + 1;
      end
    end
  end

  // reflect a polarity-0 level into the current polarity
  function automatic int mirror(int x, int pol, bit third);
    if (!third && x == 1) return 1;
    return (pol != 0) ? 3 - x : x;
  endfunction

  function automatic int off_level(bit third);
    return third ? 2 : 3;
  endfunction

  task automatic compare_all();
    logic [7:0]         e_com;
    logic [N_SEG*2-1:0] e_seg;
    for (int i = 0; i < 4; i++) begin
      int v;
      if (cfg_sleep) v = 0;
      else if (i == 3 && !cfg_quarter) begin
        bit on;
        on = !cfg_blank && disp_data[N_SEG*4 + m_phase];
        v = mirror(on ? 0 : off_level(cfg_third_bias), m_pol, cfg_third_bias);
      end else v = mirror((i == m_phase) ? 3 : 1, m_pol, cfg_third_bias);
      e_com[2*i +: 2] = 2'(v);
    end
    for (int j = 0; j < N_SEG; j++) begin
      int v;
      if (cfg_sleep) v = 0;
      else if (j < N_PORT && cfg_port_en[j]) v = port_val[j] ? 3 : 0;
      else begin
        bit on;
        on = !cfg_blank && disp_data[j*4 + m_phase];
        v = mirror(on ? 0 : off_level(cfg_third_bias), m_pol, cfg_third_bias);
      end
      e_seg[2*j +: 2] = 2'(v);
    end
    checks++;
    if (com_lvl !== e_com || seg_lvl !== e_seg) begin
      errors++;
      $display("FAIL %s: com_lvl actual %h expected %h, seg_lvl actual %h expected %h",
               cur_req, com_lvl, e_com, seg_lvl, e_seg);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) compare_all();

  task automatic wait_cycles(int n, string tag);
    cur_req = tag;
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic new_image();
    for (int b = 0; b < DW; b++) disp_data[b] = 1'($urandom);
  endtask

  task automatic check_reset(string tag);
    checks++;
    if (com_lvl !== 8'h57) begin
      errors++;
      $display("FAIL %s: reset com_lvl actual %h expected 57", tag, com_lvl);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    new_image();
    repeat (4) @(negedge clk);
    check_reset("R1");
    #1 rst_n = 1'b1;

    // R3 R4 R5: every duty/bias pair over two frames at two rates
    for (int q = 1; q >= 0; q--) begin
      for (int t = 1; t >= 0; t--) begin
        for (int r = 0; r < 2; r++) begin
          cfg_quarter = 1'(q); cfg_third_bias = 1'(t); cfg_rate = 2'(r);
          new_image();
          wait_cycles(2 * 4 * BASE_DIV * (1 << r) + 3, "R3 R4 R5");
        end
      end
    end

    // R2 R6: rate sweep, including slowing and speeding mid-phase
    cfg_quarter = 1'b1; cfg_third_bias = 1'b1;
    for (int r = 3; r >= 0; r--) begin
      cfg_rate = 2'(r);
      wait_cycles(2 * 4 * BASE_DIV * (1 << r) + 5, "R2 R6");
    end

    // R7: fourth common pin as segment
    cfg_quarter = 1'b0;
    for (int t = 0; t < 2; t++) begin
      cfg_third_bias = 1'(t);
      new_image();
      wait_cycles(3 * 2 * BASE_DIV + 7, "R7");
    end

    // R8: blank with both biases and both duties
    cfg_blank = 1'b1;
    for (int k = 0; k < 4; k++) begin
      cfg_quarter = 1'(k[0]); cfg_third_bias = 1'(k[1]);
      wait_cycles(2 * 4 * BASE_DIV, "R8");
    end
    cfg_blank = 1'b0;

    // R9: ports, with blank toggled under them
    cfg_quarter = 1'b1; cfg_third_bias = 1'b1;
    cfg_port_en = 4'b1011; port_val = 4'b0110;
    wait_cycles(3 * 4 * BASE_DIV, "R9");
    cfg_blank = 1'b1; port_val = 4'b1001;
    wait_cycles(2 * 4 * BASE_DIV, "R9");
    cfg_blank = 1'b0; cfg_port_en = '0;

    // R10: sleep freeze and resume, raised on a step boundary
    cfg_rate = 2'd1;
    wait_cycles(11, "R10");
    cfg_sleep = 1'b1;
    wait_cycles(40, "R10");
    cfg_sleep = 1'b0;
    wait_cycles(3 * 4 * BASE_DIV * 2, "R10");

    // R11: drop to three commons while on phase 3
    cfg_rate = 2'd0; cfg_quarter = 1'b1;
    for (int rep = 0; rep < 2; rep++) begin
      while (m_phase != 3) @(negedge clk);
      #1 cfg_quarter = 1'b0;
      wait_cycles(3 * 4 * BASE_DIV, "R11");
      cfg_quarter = 1'b1;
      wait_cycles(5, "R11");
    end

    // R1: reset while running
    @(negedge clk); #1 rst_n = 1'b0; cfg_third_bias = 1'b1;
    @(negedge clk);
    check_reset("R1");
    #1 rst_n = 1'b1;
    wait_cycles(2 * 4 * BASE_DIV, "R1");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule